// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block sits beside the fetch stage and tells it where to fetch next. Each cycle the fetch PC is looked up in a small set-associative cache. Every entry holds three things: the PC of a branch seen earlier, the address that branch last jumped to, and a 2-bit saturating direction counter. The stored target becomes the next fetch address only when the PC hits an entry and that entry's counter predicts taken. In every other case fetch moves on to the next sequential word.

Once a branch has resolved further down the pipeline, its outcome comes back on a separate update port, one or more cycles after the lookup. A taken branch that is not yet stored is given an entry in its set. A branch that is already stored has its target rewritten and its counter moved toward the actual outcome. Within a set, replacement uses true least-recently-used order, and an invalid way is always filled before any valid way is evicted.

Top module: `btb_top`

## Requirements
- R1: Synchronous reset (`rst` high) invalidates every entry. From the first cycle after reset, every lookup misses and `next_pc` equals `lkp_pc + 4`.
- R2: The set index is `pc[IDX_W+1:2]`. The tag is every other PC bit. `pred_hit` is 1 only when `lkp_valid` is 1 and a valid way of the indexed set holds a matching tag.
- R3: On a hit whose counter MSB is 1, `pred_taken` is 1 and `next_pc` is the stored target. On a hit whose counter MSB is 0, and on any miss, `pred_taken` is 0 and `next_pc` is `lkp_pc + 4`.
- R4: An update with `upd_taken` = 1 that misses allocates an entry. The entry takes the tag, the target `upd_target` and the counter value 2 (weakly taken), and lookups see it from the next cycle. An update with `upd_taken` = 0 that misses changes nothing, so a later lookup of that PC still misses.
- R5: An update that hits rewrites the stored target with `upd_target`. It then moves the counter up by one on taken, stopping at 3, or down by one on not taken, stopping at 0.
- R6: An allocation goes to the lowest-numbered invalid way of the set. When all ways are valid, it goes to the least recently used way.
- R7: A lookup hit makes its way the most recently used, and so does an allocation. An update hit leaves the recency order unchanged. When an allocation lands in the same set as a lookup hit in the same cycle, only the allocation changes that set's order.
- R8: A branch PC is never held in more than one way of its set.
- R9: A lookup sees the contents as they were before any update presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | A fetch PC is presented for lookup |
| lkp_pc | input | PC_W | Fetch PC |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | PC_W | Resolved target address |
| pred_hit | output | 1 | The lookup PC is a stored branch |
| pred_taken | output | 1 | The stored counter predicts taken |
| next_pc | output | PC_W | Predicted next fetch address |

## Verification
Faults in the internal state show up at the ports in different ways and after different delays.

- A corrupted tag or valid bit shows up on the very next lookup of that PC, as a missing or a spurious `pred_hit`.
- A wrong counter step shows up only after the counter crosses its midpoint: `pred_taken` flips one update too early or too late.
- A fault in the recency order stays hidden until a full set evicts an entry. The wrong branch then starts to miss, so the bench fills a set to capacity and re-probes every resident PC after each allocation.

The bench runs a behavioural model that keeps timestamps instead of age ranks. It compares all three outputs every cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
    parameter int PC_W = 32;
    parameter int SETS = 128;
    parameter int WAYS = 4;

    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = PC_W - IDX_W;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [WAY_W-1:0] way_t;
    typedef logic [1:0]       ctr_t;

    localparam ctr_t CTR_INIT = 2'b10;

    typedef struct packed {
        logic valid;
        tag_t tag;
        pc_t  target;
        ctr_t ctr;
    } entry_t;

    typedef entry_t [WAYS-1:0] set_t;
    typedef way_t   [WAYS-1:0] ages_t;

    function automatic idx_t idx_of(pc_t pc);
        return pc[IDX_W+1:2];
    endfunction

    function automatic tag_t tag_of(pc_t pc);
        return {pc[PC_W-1:IDX_W+2], pc[1:0]};
    endfunction

    function automatic ctr_t ctr_next(ctr_t c, logic taken);
        if (taken)
            return (c == 2'b11) ? c : c + 2'b01;
        else
            return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    function automatic ages_t ages_touch(ages_t a, way_t w);
        ages_t r;
        for (int i = 0; i < WAYS; i++) begin
            if (way_t'(i) == w)
                r[i] = '0;
            else if (a[i] < a[w])
                r[i] = a[i] + way_t'(1);
            else
                r[i] = a[i];
        end
        return r;
    endfunction

    function automatic ages_t ages_reset();
        ages_t r;
        for (int i = 0; i < WAYS; i++) r[i] = way_t'(i);
        return r;
    endfunction
endpackage

// File: rtl/btb_match.sv
module btb_match
    import btb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  set_t              set_i,
    input  tag_t              tag_i,
    output logic [WAYS-1:0]   hit_vec_o,
    output logic              hit_o,
    output way_t              way_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec_o[w] = set_i[w].valid && (set_i[w].tag == tag_i);
    end

    always_comb begin
        way_o = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec_o[w]) way_o = way_t'(w);
    end

    assign hit_o = |hit_vec_o;

    // R8: a branch is resident in at most one way
    assert_single_copy_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec_o));
endmodule

// File: rtl/btb_victim.sv
module btb_victim
    import btb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [WAYS-1:0] valid_i,
    input  ages_t           ages_i,
    output way_t            way_o
);
    logic [WAYS-1:0] oldest;
    logic            any_free;
    way_t            free_way;
    way_t            lru_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_old
        assign oldest[w] = (ages_i[w] == way_t'(WAYS-1));
    end

    always_comb begin
        free_way = '0;
        lru_way  = '0;
        for (int w = WAYS-1; w >= 0; w--)
            if (!valid_i[w]) free_way = way_t'(w);
        for (int w = 0; w < WAYS; w++)
            if (oldest[w]) lru_way = way_t'(w);
    end

    assign any_free = ~&valid_i;
    assign way_o    = any_free ? free_way : lru_way;

    assert_invalid_first_R6: assert property (@(posedge clk) disable iff (rst)
        any_free |-> !valid_i[way_o]);
    assert_oldest_unique_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot(oldest));
endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            lkp_valid,
    input  logic [PC_W-1:0] lkp_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] next_pc
);
    set_t  sets_q [SETS];
    ages_t ages_q [SETS];

    idx_t            l_idx, u_idx;
    set_t            l_set, u_set;
    logic [WAYS-1:0] l_vec, u_vec, u_valid;
    logic            l_hit, u_hit;
    way_t            l_way, u_way, v_way;
    logic            alloc, lkp_touch;

    assign l_idx = idx_of(lkp_pc);
    assign u_idx = idx_of(upd_pc);
    assign l_set = sets_q[l_idx];
    assign u_set = sets_q[u_idx];

    btb_match u_lkp_match (
        .clk(clk), .rst(rst), .set_i(l_set), .tag_i(tag_of(lkp_pc)),
        .hit_vec_o(l_vec), .hit_o(l_hit), .way_o(l_way)
    );

    btb_match u_upd_match (
        .clk(clk), .rst(rst), .set_i(u_set), .tag_i(tag_of(upd_pc)),
        .hit_vec_o(u_vec), .hit_o(u_hit), .way_o(u_way)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_vld
        assign u_valid[w] = u_set[w].valid;
    end

    btb_victim u_victim (
        .clk(clk), .rst(rst), .valid_i(u_valid), .ages_i(ages_q[u_idx]),
        .way_o(v_way)
    );

    assign alloc     = upd_valid && !u_hit && upd_taken;
    assign lkp_touch = lkp_valid && l_hit && !(alloc && (u_idx == l_idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) sets_q[s][w].valid <= 1'b0;
                ages_q[s] <= ages_reset();
            end
        end else begin
            if (lkp_touch)
                ages_q[l_idx] <= ages_touch(ages_q[l_idx], l_way);
            if (upd_valid && u_hit) begin
                sets_q[u_idx][u_way].target <= upd_target;
                sets_q[u_idx][u_way].ctr    <= ctr_next(u_set[u_way].ctr, upd_taken);
            end else if (alloc) begin
                sets_q[u_idx][v_way] <= '{valid: 1'b1, tag: tag_of(upd_pc),
                                          target: upd_target, ctr: CTR_INIT};
                ages_q[u_idx] <= ages_touch(ages_q[u_idx], v_way);
            end
        end
    end

    assign pred_hit   = lkp_valid && l_hit;
    assign pred_taken = pred_hit && l_set[l_way].ctr[1];
    assign next_pc    = pred_taken ? l_set[l_way].target : lkp_pc + PC_W'(4);

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !pred_hit);
    assert_taken_needs_hit_R3: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> pred_hit);
    assert_alloc_visible_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(alloc && !rst) && lkp_valid && (lkp_pc == $past(upd_pc))) |-> pred_hit);
endmodule

// File: tb/tb_btb_top.sv
module tb_btb_top;
    localparam int PW = btb_pkg::PC_W;
    localparam int NS = btb_pkg::SETS;
    localparam int NW = btb_pkg::WAYS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lkp_valid = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
    logic [PW-1:0] lkp_pc = '0, upd_pc = '0, upd_target = '0;
    logic          pred_hit, pred_taken;
    logic [PW-1:0] next_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    btb_top dut (
        .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .pred_hit(pred_hit), .pred_taken(pred_taken),
        .next_pc(next_pc)
    );

    always #2 clk = ~clk;

    // behavioural model: timestamps instead of rank counters
    bit            mv   [NS][NW];
    logic [PW-1:0] mpc  [NS][NW];
    logic [PW-1:0] mtgt [NS][NW];
    int            mctr [NS][NW];
    int            mts  [NS][NW];
    int            now = 0;

    function automatic int sidx(logic [PW-1:0] pc);
        return int'((pc >> 2) % NS);
    endfunction

    function automatic int find(logic [PW-1:0] pc);
        int s = sidx(pc);
        for (int w = 0; w < NW; w++)
            if (mv[s][w] && mpc[s][w] == pc) return w;
        return -1;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                mv[s][w] = 0; mts[s][w] = -w;
            end
    endtask

    task automatic check(string tag, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit lv, input logic [PW-1:0] lpc, input bit uv,
                        input logic [PW-1:0] upc, input bit ut,
                        input logic [PW-1:0] utg, input string tag);
        int lw, uw, ls, us, v;
        bit e_hit, e_tk, al;
        logic [PW-1:0] e_np;
        @(negedge clk);
        lkp_valid = lv; lkp_pc = lpc; upd_valid = uv; upd_pc = upd_pc;
        upd_pc = upc; upd_taken = ut; upd_target = utg;
        lw = find(lpc); ls = sidx(lpc);
        e_hit = lv && lw >= 0;
        e_tk  = e_hit && mctr[ls][lw] >= 2;
        e_np  = e_tk ? mtgt[ls][lw] : lpc + 4;
        #1;
        check(tag, "pred_hit", PW'(pred_hit), PW'(e_hit));
        check(tag, "pred_taken", PW'(pred_taken), PW'(e_tk));
        check(tag, "next_pc", next_pc, e_np);
        // state change at the coming edge
        now++;
        uw = find(upc); us = sidx(upc);
        al = uv && uw < 0 && ut;
        if (e_hit && !(al && us == ls)) mts[ls][lw] = now;
        if (uv && uw >= 0) begin
            mtgt[us][uw] = utg;
            if (ut) mctr[us][uw] = (mctr[us][uw] == 3) ? 3 : mctr[us][uw] + 1;
            else    mctr[us][uw] = (mctr[us][uw] == 0) ? 0 : mctr[us][uw] - 1;
        end else if (al) begin
            v = -1;
            for (int w = 0; w < NW; w++) if (!mv[us][w] && v < 0) v = w;
            if (v < 0) begin
                v = 0;
                for (int w = 1; w < NW; w++) if (mts[us][w] < mts[us][v]) v = w;
            end
            mv[us][v] = 1; mpc[us][v] = upc; mtgt[us][v] = utg;
            mctr[us][v] = 2; mts[us][v] = now;
        end
    endtask

    function automatic logic [PW-1:0] P(int tagv, int s);
        return PW'((tagv << (2 + $clog2(NS))) | (s << 2));
    endfunction

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: empty after reset
        for (int k = 0; k < 4; k++) step(1, P(k, 5), 0, 0, 0, 0, "R1");
        // R4: not-taken miss is not allocated
        step(0, 0, 1, P(1, 9), 0, 32'h100, "R4");
        step(1, P(1, 9), 0, 0, 0, 0, "R4");
        // R9 then R4: allocation visible only from next cycle
        step(1, P(1, 9), 1, P(1, 9), 1, 32'h4000, "R9");
        step(1, P(1, 9), 0, 0, 0, 0, "R4");
        step(0, P(1, 9), 0, 0, 0, 0, "R2");
        // R5: training and saturation, target rewrite
        step(1, P(1, 9), 1, P(1, 9), 0, 32'h4000, "R5");
        step(1, P(1, 9), 1, P(1, 9), 0, 32'h4000, "R5");
        step(1, P(1, 9), 1, P(1, 9), 0, 32'h4000, "R5");
        step(1, P(1, 9), 1, P(1, 9), 1, 32'h8800, "R5");
        step(1, P(1, 9), 1, P(1, 9), 1, 32'h8800, "R5");
        step(1, P(1, 9), 1, P(1, 9), 1, 32'h9900, "R5");
        step(1, P(1, 9), 1, P(1, 9), 1, 32'h9900, "R5");
        step(1, P(1, 9), 0, 0, 0, 0, "R3");
        // R6/R7: fill set 5, touch, evict
        for (int k = 0; k < NW; k++) step(0, 0, 1, P(k, 5), 1, PW'(32'h1000 + k * 16), "R6");
        step(1, P(0, 5), 1, P(2, 5), 1, 32'h2222, "R7");
        step(0, 0, 1, P(4, 5), 1, 32'h5000, "R6");
        for (int k = 0; k <= 4; k++) step(1, P(k, 5), 0, 0, 0, 0, "R6");
        step(1, P(3, 5), 1, P(5, 5), 1, 32'h5500, "R7");
        for (int k = 0; k <= 5; k++) step(1, P(k, 5), 0, 0, 0, 0, "R7");
        step(1, P(3, 5), 1, P(3, 5), 1, 32'h7700, "R8");
        step(1, P(3, 5), 0, 0, 0, 0, "R8");
        // random mix over two crowded sets
        for (int i = 0; i < 4000; i++) begin
            automatic int s1 = ($urandom % 2) ? 3 : 7;
            automatic int s2 = ($urandom % 2) ? 3 : 7;
            step($urandom % 4 != 0, P($urandom % 7, s1), $urandom % 2,
                 P($urandom % 7, s2), $urandom % 3 != 0,
                 PW'({$urandom % 4096, 2'b00}), "R3");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule